// File: doc/BRIEF.md
# Sleep-State Rail Sequencer

This block turns two active-high sleep-state levels into the control levels for a memory power subsystem with three rails: the main supply, the half-rail reference, and the termination regulator. When both levels are high, the system is fully awake and every rail runs. When only the deep-sleep level is high, the system is in suspend-to-RAM. In that state the main supply and the reference stay up, and the termination output floats. When the deep-sleep level is low, all rails are shut down and actively discharged.

The discharge runs in two phases. It starts in tracking mode, where the termination output follows half the main rail and carries the discharge current. Once a comparator reports that the main rail has fallen below its low threshold, the discharge switches to non-tracking mode. Each time termination is brought up, it first runs a fixed soft-start window with the high current limit selected. A supply power-on-ok level gates every output. This gate does not latch: when the flag returns, the block resumes from the present sleep-state inputs. Both sleep-state levels pass through two-flop synchronisers and a programmable debounce. The two analog flags pass through two-flop synchronisers only.

Top module: `slp_rail_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, every output is 0.
- R2: With both sleep inputs high and the supply ok, the outputs settle to main, reference and termination enabled. Float, both discharge controls and the high current limit are all 0.
- R3: With the deep-sleep input high and the other input low, main and reference are enabled, termination is disabled and the float control is 1.
- R4: With the deep-sleep input low, the main, reference and termination enables are 0 whatever the other input is. Tracking discharge is 1 and non-tracking discharge is 0 while the low-rail flag is 0.
- R5: Once the low-rail flag is seen during discharge, tracking discharge goes to 0 and non-tracking discharge goes to 1. It stays 1 even if the flag drops again, for as long as the deep-sleep input stays low.
- R6: With the supply-ok flag low, every output is 0. When the flag returns, the outputs follow the present sleep inputs with no other stimulus.
- R7: Each time termination starts, the high current limit output is 1 for exactly SS_CYCLES consecutive cycles, with termination enabled throughout, and then returns to 0.
- R8: A rise of the deep-sleep input during either discharge phase ends the discharge and restarts the enable sequence.
- R9: A pulse on either sleep input that lasts fewer than DEB_CYCLES cycles after synchronisation has no effect on any output.
- R10: Termination is never enabled while main is disabled. Float and termination enable are never both 1. The two discharge controls are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s3_in | input | 1 | Asynchronous sleep level; high keeps termination alive |
| s5_in | input | 1 | Asynchronous deep-sleep level; low shuts all rails down |
| por_ok | input | 1 | Supply power-on reset satisfied |
| vmain_low | input | 1 | Comparator: main rail below the low discharge threshold |
| main_en | output | 1 | Main supply enable |
| ref_en | output | 1 | Reference buffer enable |
| term_en | output | 1 | Termination regulator enable |
| term_hiz | output | 1 | Termination output floated |
| trk_dis_en | output | 1 | Tracking discharge active |
| ntrk_dis_en | output | 1 | Non-tracking discharge active |
| term_ilim_hi | output | 1 | High termination current limit (soft-start) |

## Verification
The bench builds the block with DEB_CYCLES = 4 and SS_CYCLES = 10. With these values every state change settles within about twenty cycles, so a table of input patterns can be walked with a fixed settle wait. The short debounce lets a two-cycle glitch fall clearly below the filter length. The short soft-start window can be counted cycle by cycle to confirm it is exactly SS_CYCLES long.

// File: rtl/slp_rail_pkg.sv
package slp_rail_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RAM   = 3'd1,
    ST_TSOFT = 3'd2,
    ST_RUN   = 3'd3,
    ST_DTRK  = 3'd4,
    ST_DNTRK = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic main_en;
    logic ref_en;
    logic term_en;
    logic term_hiz;
    logic trk_dis;
    logic ntrk_dis;
    logic ilim_hi;
  } rail_ctl_t;

  function automatic rail_ctl_t ctl_of(seq_state_e s);
    rail_ctl_t c;
    c = '0;
    case (s)
      ST_RAM:   begin c.main_en = 1'b1; c.ref_en = 1'b1; c.term_hiz = 1'b1; end
      ST_TSOFT: begin c.main_en = 1'b1; c.ref_en = 1'b1; c.term_en = 1'b1; c.ilim_hi = 1'b1; end
      ST_RUN:   begin c.main_en = 1'b1; c.ref_en = 1'b1; c.term_en = 1'b1; end
      ST_DTRK:  c.trk_dis = 1'b1;
      ST_DNTRK: c.ntrk_dis = 1'b1;
      default:  c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/slp_in_cond.sv
module slp_in_cond #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q
);

  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= d_in;
      s2 <= s1;
    end
  end

  generate
    if (DEB_CYCLES == 0) begin : g_bypass
      assign q = s2;
    end else begin : g_deb
      localparam int CW = $clog2(DEB_CYCLES + 1);
      localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);
      logic [CW-1:0] cnt;
      logic          stable;

      always_ff @(posedge clk) begin
        if (rst) begin
          stable <= 1'b0;
          cnt    <= '0;
        end else if (s2 == stable) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          stable <= s2;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      assign q = stable;

      AST_DEB_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (rst)
        !$stable(stable) |-> $past(s2) == stable); // R9
    end
  endgenerate

endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_rail_pkg::*;
#(
  parameter int SS_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       s3,
  input  logic       s5,
  input  logic       por,
  input  logic       mlow,
  output seq_state_e nxt
);

  localparam int SW = $clog2(SS_CYCLES + 1);
  localparam logic [SW-1:0] SS_LAST = SW'(SS_CYCLES - 1);

  seq_state_e    cur;
  logic [SW-1:0] ss_cnt;
  seq_state_e    wake_st;

  always_comb wake_st = s3 ? ST_TSOFT : ST_RAM;

  always_comb begin
    nxt = cur;
    if (!por) begin
      nxt = ST_IDLE;
    end else begin
      case (cur)
        ST_IDLE:  nxt = s5 ? wake_st : ST_DTRK;
        ST_RAM:   if (!s5) nxt = ST_DTRK; else if (s3) nxt = ST_TSOFT;
        ST_TSOFT: begin
          if (!s5)                  nxt = ST_DTRK;
          else if (!s3)             nxt = ST_RAM;
          else if (ss_cnt == SS_LAST) nxt = ST_RUN;
        end
        ST_RUN:   if (!s5) nxt = ST_DTRK; else if (!s3) nxt = ST_RAM;
        ST_DTRK:  if (s5) nxt = wake_st; else if (mlow) nxt = ST_DNTRK;
        ST_DNTRK: if (s5) nxt = wake_st;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= ST_IDLE;
      ss_cnt <= '0;
    end else begin
      cur <= nxt;
      if (cur == ST_TSOFT && nxt == ST_TSOFT) ss_cnt <= ss_cnt + 1'b1;
      else                                    ss_cnt <= '0;
    end
  end

  AST_SS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    cur == ST_TSOFT |-> ss_cnt <= SS_LAST); // R7
  AST_WAKE_ABORTS_DIS: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_DTRK || cur == ST_DNTRK) && s5 && por |=> cur == ST_RAM || cur == ST_TSOFT); // R8

endmodule

// File: rtl/slp_out_reg.sv
module slp_out_reg
  import slp_rail_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e nxt,
  output rail_ctl_t  ctl
);

  always_ff @(posedge clk) begin
    if (rst) ctl <= '0;
    else     ctl <= ctl_of(nxt);
  end

endmodule

// File: rtl/slp_rail_ctrl.sv
module slp_rail_ctrl
  import slp_rail_pkg::*;
#(
  parameter int DEB_CYCLES = 16,
  parameter int SS_CYCLES  = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic s3_in,
  input  logic s5_in,
  input  logic por_ok,
  input  logic vmain_low,
  output logic main_en,
  output logic ref_en,
  output logic term_en,
  output logic term_hiz,
  output logic trk_dis_en,
  output logic ntrk_dis_en,
  output logic term_ilim_hi
);

  localparam int NIN = 4;

  logic [NIN-1:0] raw, cond;
  seq_state_e     nxt;
  rail_ctl_t      ctl;

  assign raw = {vmain_low, por_ok, s5_in, s3_in};

  generate
    for (genvar g = 0; g < NIN; g++) begin : g_in
      slp_in_cond #(.DEB_CYCLES(g < 2 ? DEB_CYCLES : 0)) i_cond (
        .clk (clk),
        .rst (rst),
        .d_in(raw[g]),
        .q   (cond[g])
      );
    end
  endgenerate

  slp_seq #(.SS_CYCLES(SS_CYCLES)) i_seq (
    .clk (clk),
    .rst (rst),
    .s3  (cond[0]),
    .s5  (cond[1]),
    .por (cond[2]),
    .mlow(cond[3]),
    .nxt (nxt)
  );

  slp_out_reg i_out (
    .clk(clk),
    .rst(rst),
    .nxt(nxt),
    .ctl(ctl)
  );

  assign main_en      = ctl.main_en;
  assign ref_en       = ctl.ref_en;
  assign term_en      = ctl.term_en;
  assign term_hiz     = ctl.term_hiz;
  assign trk_dis_en   = ctl.trk_dis;
  assign ntrk_dis_en  = ctl.ntrk_dis;
  assign term_ilim_hi = ctl.ilim_hi;

  AST_TERM_NEEDS_MAIN: assert property (@(posedge clk) disable iff (rst)
    term_en |-> main_en); // R10
  AST_HIZ_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({term_en, term_hiz}) <= 1); // R10
  AST_DIS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trk_dis_en, ntrk_dis_en})); // R10
  AST_POR_GATES: assert property (@(posedge clk) disable iff (rst)
    !cond[2] |=> ctl == '0); // R6
  AST_S5_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
    !cond[1] |=> !main_en && !term_en); // R4
  AST_NTRK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ntrk_dis_en && !cond[1] && cond[2] |=> ntrk_dis_en); // R5
  AST_ILIM_WITH_TERM: assert property (@(posedge clk) disable iff (rst)
    term_ilim_hi |-> term_en); // R7

endmodule

// File: tb/test_slp_rail_ctrl.sv
module test_slp_rail_ctrl;

  localparam int DEB = 4;
  localparam int SS  = 10;
  localparam int SETTLE = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s3_in = 1'b0, s5_in = 1'b0, por_ok = 1'b0, vmain_low = 1'b0;
  logic main_en, ref_en, term_en, term_hiz, trk_dis_en, ntrk_dis_en, term_ilim_hi;

  int checks = 0;
  int errors = 0;
  int inv_bad = 0;

  always #10 clk = ~clk;

  slp_rail_ctrl #(.DEB_CYCLES(DEB), .SS_CYCLES(SS)) i_slp_rail_ctrl (
    .clk(clk), .rst(rst), .s3_in(s3_in), .s5_in(s5_in), .por_ok(por_ok),
    .vmain_low(vmain_low), .main_en(main_en), .ref_en(ref_en), .term_en(term_en),
    .term_hiz(term_hiz), .trk_dis_en(trk_dis_en), .ntrk_dis_en(ntrk_dis_en),
    .term_ilim_hi(term_ilim_hi)
  );

  function automatic logic [6:0] outs();
    return {main_en, ref_en, term_en, term_hiz, trk_dis_en, ntrk_dis_en, term_ilim_hi};
  endfunction

  // inputs {s3,s5,por,mlow} then expected {main,ref,term,hiz,trk,ntrk,ilim}
  localparam int NV = 12;
  localparam logic [10:0] TBL [NV] = '{
    {4'b1110, 7'b1110000},  // R2 awake
    {4'b0110, 7'b1101000},  // R3 suspend
    {4'b1110, 7'b1110000},  // R2 back awake
    {4'b1010, 7'b0000100},  // R4 s5 low, s3 high ignored
    {4'b1011, 7'b0000010},  // R5 low rail seen
    {4'b0010, 7'b0000010},  // R5 stays non-tracking
    {4'b0110, 7'b1101000},  // R8 wake aborts discharge
    {4'b0100, 7'b0000000},  // R6 supply not ok
    {4'b0110, 7'b1101000},  // R6 supply back, resumes
    {4'b0010, 7'b0000100},  // R4 tracking discharge
    {4'b1110, 7'b1110000},  // R8 wake from tracking
    {4'b1011, 7'b0000010}   // R5 straight through
  };
  localparam int TREQ [NV] = '{2, 3, 2, 4, 5, 5, 8, 6, 6, 4, 8, 5};

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && ((term_en && !main_en) || (term_en && term_hiz) || (trk_dis_en && ntrk_dis_en)))
      inv_bad++;
  end

  initial begin : watchdog
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int hi_cnt;
    int bad;
    cyc(3);
    chk("R1 in reset", outs(), 7'b0);
    rst = 1'b0;
    cyc(1);
    chk("R1 after reset", outs(), 7'b0);

    for (int v = 0; v < NV; v++) begin
      {s3_in, s5_in, por_ok, vmain_low} = TBL[v][10:7];
      cyc(SETTLE);
      chk($sformatf("R%0d vector %0d", TREQ[v], v), outs(), TBL[v][6:0]);
    end

    // R7: soft-start window length
    {s3_in, s5_in, por_ok, vmain_low} = 4'b0110;
    cyc(SETTLE);
    s3_in = 1'b1;
    hi_cnt = 0; bad = 0;
    for (int i = 0; i < 60; i++) begin
      cyc(1);
      if (term_ilim_hi) begin
        hi_cnt++;
        if (!term_en) bad++;
      end
    end
    chk("R7 soft-start length", 7'(hi_cnt), 7'(SS));
    chk("R7 term enabled during soft-start", 7'(bad), 7'd0);
    chk("R7 run after soft-start", outs(), 7'b1110000);

    // R9: short glitch on s3 while awake
    bad = 0;
    s3_in = 1'b0; cyc(2); s3_in = 1'b1;
    for (int i = 0; i < SETTLE; i++) begin
      cyc(1);
      if (outs() !== 7'b1110000) bad++;
    end
    chk("R9 s3 glitch ignored", 7'(bad), 7'd0);

    // R9: short glitch on s5 while awake
    bad = 0;
    s5_in = 1'b0; cyc(2); s5_in = 1'b1;
    for (int i = 0; i < SETTLE; i++) begin
      cyc(1);
      if (outs() !== 7'b1110000) bad++;
    end
    chk("R9 s5 glitch ignored", 7'(bad), 7'd0);

    // R6: supply drop from full run then return
    por_ok = 1'b0; cyc(SETTLE);
    chk("R6 run, supply lost", outs(), 7'b0);
    por_ok = 1'b1; cyc(SETTLE);
    chk("R6 run, supply back", outs(), 7'b1110000);

    chk("R10 invariant violations", 7'(inv_bad), 7'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule